// File: doc/BRIEF.md
# MII Transmit Line-Symbol Inserter

This block sits between an external Ethernet MAC and the control channel of a radio link. The MAC drives a 4-bit nibble interface with enable, error and data. The block turns that stream into 5-bit line symbols at one symbol per clock. All logic runs on a single transmit clock, and the symbol output is registered.

Outside a packet the block sends idle. When the MAC raises its enable, the block writes a start delimiter made of a J symbol and a K symbol. It then accepts nibbles and encodes each with the 4B/5B data table. A nibble flagged as errored becomes a halt symbol. When enable drops, the block closes the packet with a T symbol and an R symbol, then returns to idle.

A ready output paces the MAC. Ready is high while the block can consume a nibble. It is low during the slots in which delimiter symbols are being written. Until the first nibble of a packet arrives, the block fills each slot with an idle symbol.

Top module: `mii_sym_inserter`

## Requirements
- R1: During and right after reset, `sym` is idle (11111) and `tx_rdy` is high.
- R2: When `tx_en` is high in a clock where no packet is active, the next two symbols are J (11000) and then K (10001). The `txd` value in that start clock is not consumed.
- R3: The slot after K is idle (11111). After that, `tx_rdy` is high, and each clock in which `tx_en` is low before the packet's first nibble yields another idle symbol.
- R4: `tx_rdy` is low in every clock where `sym` shows J, K, T or R. Inputs in those clocks are ignored.
- R5: Each clock with `tx_rdy` high, `tx_en` high and `tx_er` low inside a packet yields the 4B/5B code of `txd` on the next clock. The codes for nibbles 0 to F are: 11110, 01001, 10100, 10101, 01010, 01011, 01110, 01111, 10010, 10011, 10110, 10111, 11010, 11011, 11100, 11101.
- R6: A consumed nibble with `tx_er` high is replaced by halt (00100), whatever `txd` holds.
- R7: When `tx_en` is low inside a packet after at least one nibble, the next symbols are T (01101) and then R (00111). Idle follows, and `tx_rdy` is high again.
- R8: With no packet active and `tx_en` low, `sym` stays idle whatever `tx_er` and `txd` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | MAC enable: packet active / nibble valid |
| tx_er | input | 1 | MAC coding error for the current nibble |
| txd | input | 4 | MAC data nibble |
| tx_rdy | output | 1 | High when the block consumes inputs this clock |
| sym | output | 5 | Registered 5-bit line symbol |

## Verification
The hardest case to reach is the padding window. This is the stretch after the start delimiter in which ready is high but the MAC has not yet sent a nibble. In that window a low enable must produce idle, not an end-of-packet. The bench reaches it by starting a packet and then holding enable low for several ready clocks before the first nibble. It then ends the same packet to show that the end delimiter appears only after data has flowed. Back-to-back packets and a halt inside a packet cover the transitions into and out of idle.

// File: rtl/mii_sym_inserter.sv
module mii_sym_inserter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_en,
  input  logic       tx_er,
  input  logic [3:0] txd,
  output logic       tx_rdy,
  output logic [4:0] sym
);
  localparam logic [4:0] S_IDLE = 5'b11111;
  localparam logic [4:0] S_J    = 5'b11000;
  localparam logic [4:0] S_K    = 5'b10001;
  localparam logic [4:0] S_T    = 5'b01101;
  localparam logic [4:0] S_R    = 5'b00111;
  localparam logic [4:0] S_HALT = 5'b00100;

  typedef enum logic [2:0] {ST_IDLE, ST_SOP_J, ST_SOP_K, ST_DATA, ST_EOP_T, ST_EOP_R} st_t;

  st_t        st, st_nx;
  logic       seen, seen_nx;
  logic [4:0] sym_nx;

  function automatic logic [4:0] enc(input logic [3:0] n);
    case (n)
      4'h0: enc = 5'b11110;  4'h1: enc = 5'b01001;
      4'h2: enc = 5'b10100;  4'h3: enc = 5'b10101;
      4'h4: enc = 5'b01010;  4'h5: enc = 5'b01011;
      4'h6: enc = 5'b01110;  4'h7: enc = 5'b01111;
      4'h8: enc = 5'b10010;  4'h9: enc = 5'b10011;
      4'hA: enc = 5'b10110;  4'hB: enc = 5'b10111;
      4'hC: enc = 5'b11010;  4'hD: enc = 5'b11011;
      4'hE: enc = 5'b11100;  default: enc = 5'b11101;
    endcase
  endfunction

  assign tx_rdy = (st == ST_IDLE) || (st == ST_DATA);

  always_comb begin
    st_nx   = st;
    seen_nx = seen;
    sym_nx  = S_IDLE;
    case (st)
      ST_IDLE:  if (tx_en) begin st_nx = ST_SOP_J; sym_nx = S_J; end
      ST_SOP_J: begin st_nx = ST_SOP_K; sym_nx = S_K; end
      ST_SOP_K: begin st_nx = ST_DATA; seen_nx = 1'b0; end
      ST_DATA:
        if (tx_en) begin
          seen_nx = 1'b1;
          sym_nx  = tx_er ? S_HALT : enc(txd);
        end else if (seen) begin
          st_nx  = ST_EOP_T;
          sym_nx = S_T;
        end
      ST_EOP_T: begin st_nx = ST_EOP_R; sym_nx = S_R; end
      ST_EOP_R: st_nx = ST_IDLE;
      default:  st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      seen <= 1'b0;
      sym  <= S_IDLE;
    end else begin
      st   <= st_nx;
      seen <= seen_nx;
      sym  <= sym_nx;
    end
  end

  AST_START_J:   assert property (@(posedge clk) disable iff (!rst_n) (st == ST_IDLE && tx_en) |=> sym == S_J);        // R2
  AST_J_THEN_K:  assert property (@(posedge clk) disable iff (!rst_n) (sym == S_J) |=> sym == S_K);                    // R2
  AST_DELIM_RDY: assert property (@(posedge clk) disable iff (!rst_n) (sym == S_J || sym == S_K || sym == S_T || sym == S_R) |-> !tx_rdy); // R4
  AST_HALT:      assert property (@(posedge clk) disable iff (!rst_n) (st == ST_DATA && tx_en && tx_er) |=> sym == S_HALT); // R6
  AST_T_THEN_R:  assert property (@(posedge clk) disable iff (!rst_n) (sym == S_T) |=> sym == S_R);                    // R7
  AST_R_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n) (sym == S_R) |=> (sym == S_IDLE && tx_rdy));      // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (st == ST_IDLE && !tx_en) |=> sym == S_IDLE);    // R8
endmodule

// File: tb/tb_mii_sym_inserter.sv
module tb_mii_sym_inserter;
  logic clk = 1'b0, rst_n = 1'b0, tx_en = 1'b0, tx_er = 1'b0;
  logic [3:0] txd = 4'h0;
  logic tx_rdy;
  logic [4:0] sym;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  localparam logic [4:0] IDL = 5'b11111, J = 5'b11000, K = 5'b10001,
                         T = 5'b01101, R = 5'b00111, H = 5'b00100;

  mii_sym_inserter dut (.clk(clk), .rst_n(rst_n), .tx_en(tx_en), .tx_er(tx_er),
                        .txd(txd), .tx_rdy(tx_rdy), .sym(sym));

  always #10 clk = ~clk;

  function automatic logic [4:0] code(input logic [3:0] n);
    logic [4:0] t [16] = '{5'b11110, 5'b01001, 5'b10100, 5'b10101, 5'b01010, 5'b01011,
                           5'b01110, 5'b01111, 5'b10010, 5'b10011, 5'b10110, 5'b10111,
                           5'b11010, 5'b11011, 5'b11100, 5'b11101};
    return t[n];
  endfunction

  task automatic chk(input string req, input logic [4:0] act, input logic [4:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // Starts and ends at a falling edge: drive, check ready, clock, check symbol.
  task automatic slot(input logic en, input logic er, input logic [3:0] d,
                      input logic exp_rdy, input logic [4:0] exp_sym, input string req);
    tx_en = en; tx_er = er; txd = d;
    #2;
    chk({req, " rdy"}, {4'b0, tx_rdy}, {4'b0, exp_rdy});
    @(negedge clk);
    chk({req, " sym"}, sym, exp_sym);
  endtask

  task automatic start_pkt(input logic [3:0] d);
    slot(1, 0, d, 1, J, "R2 J");
    slot(1, 0, d, 0, K, "R2 K / R4");
    slot(1, 0, d, 0, IDL, "R3 after K / R4");
  endtask

  task automatic end_pkt();
    slot(0, 0, 4'h0, 1, T, "R7 T");
    slot(0, 0, 4'h0, 0, R, "R7 R / R4");
    slot(0, 0, 4'h0, 0, IDL, "R7 idle / R4");
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 sym in reset", sym, IDL);
    chk("R1 rdy in reset", {4'b0, tx_rdy}, 5'd1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 sym after reset", sym, IDL);
  endtask

  task automatic t_idle_hold();
    slot(0, 1, 4'hA, 1, IDL, "R8 er ignored");
    slot(0, 0, 4'h5, 1, IDL, "R8 txd ignored");
  endtask

  task automatic t_all_nibbles();
    start_pkt(4'h7);
    for (int i = 0; i < 16; i++) slot(1, 0, 4'(i), 1, code(4'(i)), "R5 data");
    end_pkt();
  endtask

  task automatic t_padding();
    start_pkt(4'h3);
    for (int i = 0; i < 3; i++) slot(0, 1, 4'h9, 1, IDL, "R3 pad");
    slot(1, 0, 4'hC, 1, code(4'hC), "R5 first after pad");
    end_pkt();
  endtask

  task automatic t_halt();
    start_pkt(4'h1);
    slot(1, 0, 4'h2, 1, code(4'h2), "R5 before halt");
    slot(1, 1, 4'h2, 1, H, "R6 halt");
    slot(1, 1, 4'hF, 1, H, "R6 halt 2");
    slot(1, 0, 4'h4, 1, code(4'h4), "R5 after halt");
    end_pkt();
  endtask

  task automatic t_back_to_back();
    start_pkt(4'h0);
    slot(1, 0, 4'hE, 1, code(4'hE), "R5 pkt a");
    end_pkt();
    start_pkt(4'h0);
    slot(1, 0, 4'h8, 1, code(4'h8), "R5 pkt b");
    end_pkt();
    slot(0, 0, 4'h0, 1, IDL, "R8 idle after");
  endtask

  initial begin
    t_reset();
    t_idle_hold();
    t_all_nibbles();
    t_padding();
    t_halt();
    t_back_to_back();
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule